// File: doc/BRIEF.md
# Tagged Capability Memory

This block is a small on-chip memory that stores, next to every naturally aligned 16-byte slot, one hidden validity bit. The bit says that the slot holds a genuine 128-bit capability. Two kinds of requests use the memory. Capability requests move a whole slot together with its validity bit. Ordinary data requests move a byte, a half-word, a word or a double-word, and they never see the bit.

Only a capability store can set the bit, and only when the stored value carries a set bit itself. Any ordinary data write into a slot clears that slot's bit. An overwritten pointer therefore cannot be loaded back as a valid capability. A capability access that does not start on a 16-byte boundary is refused with an error and changes nothing. The same applies to a data access that is not aligned to its own size.

Requests arrive on a valid/ready channel. Each accepted request produces exactly one response strobe on the following cycle, carrying read data, the validity bit and an error flag.

Top module: `tagged_cap_mem`

## Requirements
- R1: A synchronous reset clears every slot's validity bit. During reset `rsp_valid` is 0 and `req_ready` is 0. Slot data is not cleared by reset.
- R2: A capability store (`req_op`=3) to a 16-byte aligned address writes all 128 bits of `req_wdata` and sets the slot's bit to `req_wtag`. A later capability load (`req_op`=2) returns those 128 bits and that bit.
- R3: A capability store whose `req_wtag` is 0 writes the data and leaves the slot's bit at 0.
- R4: An accepted, aligned data store (`req_op`=1) writes only the addressed bytes of the slot and clears that slot's validity bit.
- R5: A data load (`req_op`=0) always returns `rsp_tag`=0, even when the slot holds a valid capability.
- R6: A capability load or store whose address bits [3:0] are not zero returns `rsp_err`=1 with zero data and zero tag. It leaves slot data and validity bits unchanged.
- R7: A data access whose address is not a multiple of its size returns `rsp_err`=1 and leaves memory and validity bits unchanged. Size codes: 0 byte, 1 half, 2 word, 3 double.
- R8: `req_ready` is 1 whenever reset is low. Each accepted request gives `rsp_valid`=1 exactly one cycle later, and `rsp_valid` is 0 in a cycle that follows no accepted request.
- R9: Data is little-endian within a slot. A data load returns the addressed bytes, starting at byte `addr[3:0]`, zero-extended in `rsp_rdata` bit 0 upward. A data store takes its value from the low bytes of `req_wdata`. Store responses return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 2 | 0 data load, 1 data store, 2 capability load, 3 capability store |
| req_size | input | 2 | Data access size, 0 byte to 3 double-word (ignored for capability ops) |
| req_addr | input | ADDR_W (8) | Byte address |
| req_wdata | input | 128 | Store data |
| req_wtag | input | 1 | Validity bit of the stored capability |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Alignment error |
| rsp_rdata | output | 128 | Load data |
| rsp_tag | output | 1 | Validity bit returned by capability loads |

## Verification
Every response is due on the rising edge after the edge that accepts the request. The bench drives a request on a falling edge, lets one rising edge accept it, and samples all response outputs on the next falling edge, when the response registers have settled. Effects on storage are due on the accepting edge. They are observed through a capability load issued straight after, whose own response comes one cycle later. Reset effects are sampled on the falling edge after the reset edge.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

    localparam int CAP_BYTES = 16;
    localparam int CAP_W     = CAP_BYTES * 8;
    localparam int OFF_W     = $clog2(CAP_BYTES);

    typedef enum logic [1:0] {
        OP_DLOAD  = 2'd0,
        OP_DSTORE = 2'd1,
        OP_CLOAD  = 2'd2,
        OP_CSTORE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } size_e;

    typedef struct packed {
        logic                 is_cap;
        logic                 is_wr;
        logic                 err;
        logic [OFF_W-1:0]     off;
        size_e                sz;
        logic [CAP_BYTES-1:0] bmask;
    } dec_t;

    function automatic logic [CAP_BYTES-1:0] width_bytes(input size_e sz);
        case (sz)
            SZ_BYTE: return CAP_BYTES'(16'h0001);
            SZ_HALF: return CAP_BYTES'(16'h0003);
            SZ_WORD: return CAP_BYTES'(16'h000F);
            default: return CAP_BYTES'(16'h00FF);
        endcase
    endfunction

    function automatic logic [CAP_W-1:0] width_bits(input size_e sz);
        case (sz)
            SZ_BYTE: return {{(CAP_W-8){1'b0}},  {8{1'b1}}};
            SZ_HALF: return {{(CAP_W-16){1'b0}}, {16{1'b1}}};
            SZ_WORD: return {{(CAP_W-32){1'b0}}, {32{1'b1}}};
            default: return {{(CAP_W-64){1'b0}}, {64{1'b1}}};
        endcase
    endfunction

    function automatic logic off_bad(input logic is_cap, input size_e sz,
                                     input logic [OFF_W-1:0] off);
        logic [OFF_W-1:0] low;
        if (is_cap) return off != '0;
        case (sz)
            SZ_BYTE: low = '0;
            SZ_HALF: low = OFF_W'(1);
            SZ_WORD: low = OFF_W'(3);
            default: low = OFF_W'(7);
        endcase
        return (off & low) != '0;
    endfunction

endpackage

// File: rtl/tcm_req_decode.sv
module tcm_req_decode
    import tcm_pkg::*;
#(
    parameter int SLOT_W = 4
) (
    input  logic [1:0]              op,
    input  logic [1:0]              size,
    input  logic [SLOT_W+OFF_W-1:0] addr,
    output dec_t                    dec,
    output logic [SLOT_W-1:0]       slot
);
    op_e   op_q;
    size_e sz_q;

    always_comb begin
        op_q       = op_e'(op);
        sz_q       = size_e'(size);
        dec.is_cap = (op_q == OP_CLOAD) || (op_q == OP_CSTORE);
        dec.is_wr  = (op_q == OP_DSTORE) || (op_q == OP_CSTORE);
        dec.off    = addr[OFF_W-1:0];
        dec.sz     = sz_q;
        dec.err    = off_bad(dec.is_cap, sz_q, addr[OFF_W-1:0]);
        dec.bmask  = dec.is_cap ? {CAP_BYTES{1'b1}}
                                : (width_bytes(sz_q) << addr[OFF_W-1:0]);
        slot       = addr[SLOT_W+OFF_W-1:OFF_W];
    end
endmodule

// File: rtl/tcm_data_array.sv
module tcm_data_array
    import tcm_pkg::*;
#(
    parameter int SLOTS  = 16,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [SLOT_W-1:0]    wr_slot,
    input  logic [CAP_BYTES-1:0] wr_mask,
    input  logic [CAP_W-1:0]     wr_data,
    input  logic [SLOT_W-1:0]    rd_slot,
    output logic [CAP_W-1:0]     rd_data
);
    logic [CAP_W-1:0] mem [SLOTS];

    for (genvar b = 0; b < CAP_BYTES; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[b])
                mem[wr_slot][b*8 +: 8] <= wr_data[b*8 +: 8];
        end
    end

    assign rd_data = mem[rd_slot];
endmodule

// File: rtl/tcm_tag_array.sv
module tcm_tag_array #(
    parameter int SLOTS  = 16,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              put_en,
    input  logic              put_val,
    input  logic              wipe_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic              rd_tag
);
    logic [SLOTS-1:0] tags;

    always_ff @(posedge clk) begin
        if (rst)
            tags <= '0;
        else if (put_en)
            tags[wr_slot] <= put_val;
        else if (wipe_en)
            tags[wr_slot] <= 1'b0;
    end

    assign rd_tag = tags[rd_slot];

    // R1: a reset edge leaves every tag clear
    p_tags_clear_r1: assert property (@(posedge clk) rst |=> (tags == '0));

    // R2: no tag rises unless a capability store wrote it
    p_tag_rise_source_r2: assert property (@(posedge clk) disable iff (rst)
        !put_en |=> ((tags & ~$past(tags)) == '0));

    // R4: a data write leaves the touched slot's tag clear
    p_wipe_r4: assert property (@(posedge clk) disable iff (rst)
        (wipe_en && !put_en) |=> !tags[$past(wr_slot)]);
endmodule

// File: rtl/tagged_cap_mem.sv
module tagged_cap_mem
    import tcm_pkg::*;
#(
    parameter int SLOTS  = 16,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int ADDR_W = SLOT_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CAP_W-1:0]  req_wdata,
    input  logic              req_wtag,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [CAP_W-1:0]  rsp_rdata,
    output logic              rsp_tag
);
    dec_t              dec;
    logic [SLOT_W-1:0] slot;
    logic              accept;
    logic              do_write;
    logic [CAP_W-1:0]  wr_data;
    logic [CAP_W-1:0]  rd_data;
    logic              rd_tag;
    logic [CAP_W-1:0]  rd_next;
    logic              tag_next;

    assign req_ready = !rst;
    assign accept    = req_valid && req_ready;
    assign do_write  = accept && dec.is_wr && !dec.err;

    tcm_req_decode #(.SLOT_W(SLOT_W)) u_dec (
        .op   (req_op),
        .size (req_size),
        .addr (req_addr),
        .dec  (dec),
        .slot (slot)
    );

    assign wr_data = dec.is_cap ? req_wdata : (req_wdata << {dec.off, 3'b000});

    tcm_data_array #(.SLOTS(SLOTS)) u_data (
        .clk     (clk),
        .wr_en   (do_write),
        .wr_slot (slot),
        .wr_mask (dec.bmask),
        .wr_data (wr_data),
        .rd_slot (slot),
        .rd_data (rd_data)
    );

    tcm_tag_array #(.SLOTS(SLOTS)) u_tag (
        .clk     (clk),
        .rst     (rst),
        .put_en  (do_write && dec.is_cap),
        .put_val (req_wtag),
        .wipe_en (do_write && !dec.is_cap),
        .wr_slot (slot),
        .rd_slot (slot),
        .rd_tag  (rd_tag)
    );

    always_comb begin
        rd_next  = '0;
        tag_next = 1'b0;
        if (!dec.err && !dec.is_wr) begin
            if (dec.is_cap) begin
                rd_next  = rd_data;
                tag_next = rd_tag;
            end else begin
                rd_next = (rd_data >> {dec.off, 3'b000}) & width_bits(dec.sz);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
            rsp_tag   <= 1'b0;
        end else begin
            rsp_valid <= accept;
            rsp_err   <= accept && dec.err;
            rsp_rdata <= accept ? rd_next : '0;
            rsp_tag   <= accept && tag_next;
        end
    end

    // R8: one response strobe per accepted request, one cycle later
    p_rsp_timing_r8: assert property (@(posedge clk) disable iff (rst)
        accept |=> rsp_valid);
    p_rsp_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !rsp_valid);

    // R6: unaligned capability access is reported and carries no tag
    p_cap_misalign_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && req_op[1] && (req_addr[OFF_W-1:0] != '0)) |=> (rsp_err && !rsp_tag));

    // R5: data loads never show the tag
    p_data_no_tag_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && (req_op == 2'd0)) |=> !rsp_tag);

    // R7: odd half-word data access is refused
    p_data_misalign_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_op[1] && (req_size == 2'd1) && req_addr[0]) |=> rsp_err);
endmodule

// File: tb/tb_tagged_cap_mem.sv
module tb_tagged_cap_mem;

    localparam int AW = 8;

    typedef struct packed {
        logic [1:0]   op;
        logic [1:0]   sz;
        logic [7:0]   addr;
        logic [127:0] wd;
        logic         wt;
        logic         xe;
        logic         xt;
        logic [127:0] xd;
        logic [7:0]   rq;
    } vec_t;

    localparam logic [127:0] VA  = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    localparam logic [127:0] VA2 = 128'h00112233_44556677_8899EEBB_CCDDEEFF;
    localparam logic [127:0] VB  = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
    localparam logic [127:0] VC  = 128'hCAFE0000_11111111_22222222_33333333;
    localparam logic [127:0] VC2 = 128'h11223344_11111111_22222222_33333333;
    localparam logic [127:0] VD  = 128'hDEADBEEF_DEADBEEF_DEADBEEF_DEADBEEF;
    localparam logic [127:0] Z   = 128'h0;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{2'd3, 2'd0, 8'h10, VA,  1'b1, 1'b0, 1'b0, Z,   8'd2}, // R2 store tagged
        '{2'd2, 2'd0, 8'h10, Z,   1'b0, 1'b0, 1'b1, VA,  8'd2}, // R2 load back
        '{2'd0, 2'd3, 8'h18, Z,   1'b0, 1'b0, 1'b0, 128'h00112233_44556677, 8'd5}, // R5 upper dword, no tag
        '{2'd0, 2'd0, 8'h13, Z,   1'b0, 1'b0, 1'b0, 128'hCC, 8'd9}, // R9 byte lane 3
        '{2'd1, 2'd0, 8'h15, 128'hEE, 1'b0, 1'b0, 1'b0, Z, 8'd4}, // R4 byte store
        '{2'd2, 2'd0, 8'h10, Z,   1'b0, 1'b0, 1'b0, VA2, 8'd4}, // R4 tag gone, one byte changed
        '{2'd3, 2'd0, 8'h20, VB,  1'b0, 1'b0, 1'b0, Z,   8'd3}, // R3 untagged store
        '{2'd2, 2'd0, 8'h20, Z,   1'b0, 1'b0, 1'b0, VB,  8'd3}, // R3 data kept, tag clear
        '{2'd3, 2'd0, 8'h30, VC,  1'b1, 1'b0, 1'b0, Z,   8'd2}, // R2
        '{2'd2, 2'd0, 8'h38, Z,   1'b0, 1'b1, 1'b0, Z,   8'd6}, // R6 unaligned load
        '{2'd2, 2'd0, 8'h30, Z,   1'b0, 1'b0, 1'b1, VC,  8'd6}, // R6
        '{2'd3, 2'd0, 8'h34, VD,  1'b1, 1'b1, 1'b0, Z,   8'd6}, // R6 unaligned store
        '{2'd2, 2'd0, 8'h30, Z,   1'b0, 1'b0, 1'b1, VC,  8'd6}, // R6 nothing changed
        '{2'd1, 2'd1, 8'h31, 128'h5555, 1'b0, 1'b1, 1'b0, Z, 8'd7}, // R7 odd half store
        '{2'd2, 2'd0, 8'h30, Z,   1'b0, 1'b0, 1'b1, VC,  8'd7}, // R7 tag and data intact
        '{2'd1, 2'd2, 8'h3C, 128'h11223344, 1'b0, 1'b0, 1'b0, Z, 8'd4}, // R4 word store
        '{2'd2, 2'd0, 8'h30, Z,   1'b0, 1'b0, 1'b0, VC2, 8'd4}, // R4
        '{2'd0, 2'd1, 8'h3E, Z,   1'b0, 1'b0, 1'b0, 128'h1122, 8'd9}  // R9 half at top
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic          req_ready;
    logic [1:0]    req_op;
    logic [1:0]    req_size;
    logic [AW-1:0] req_addr;
    logic [127:0]  req_wdata;
    logic          req_wtag;
    logic          rsp_valid;
    logic          rsp_err;
    logic [127:0]  rsp_rdata;
    logic          rsp_tag;

    int n_chk  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tagged_cap_mem dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_wtag  (req_wtag),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .rsp_tag   (rsp_tag)
    );

    task automatic chk(input bit ok, input string what,
                       input logic [130:0] act, input logic [130:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // drive at a falling edge, accept on the rising edge, sample at the next falling edge
    task automatic issue(input logic [1:0] op, input logic [1:0] sz, input logic [7:0] addr,
                         input logic [127:0] wd, input logic wt);
        req_valid = 1'b1;
        req_op    = op;
        req_size  = sz;
        req_addr  = addr;
        req_wdata = wd;
        req_wtag  = wt;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        req_op = 2'd0;
        req_size = 2'd0;
        req_addr = '0;
        req_wdata = '0;
        req_wtag = 1'b0;
        repeat (3) @(negedge clk);
        // R1, R8: outputs during reset
        chk(!rsp_valid && !req_ready, "R1 R8 reset outputs",
            {129'd0, rsp_valid, req_ready}, 131'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !rsp_valid, "R8 ready after reset",
            {129'd0, req_ready, rsp_valid}, {129'd0, 2'b10});

        // R1: slots start untagged
        issue(2'd2, 2'd0, 8'h00, Z, 1'b0);
        chk(rsp_valid && !rsp_err && !rsp_tag, "R1 slot 0 tag after reset",
            {128'd0, rsp_valid, rsp_err, rsp_tag}, {128'd0, 3'b100});
        issue(2'd2, 2'd0, 8'hF0, Z, 1'b0);
        chk(rsp_valid && !rsp_err && !rsp_tag, "R1 slot 15 tag after reset",
            {128'd0, rsp_valid, rsp_err, rsp_tag}, {128'd0, 3'b100});

        // vector table, back to back
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].sz, VECS[i].addr, VECS[i].wd, VECS[i].wt);
            chk({rsp_valid, rsp_err, rsp_tag, rsp_rdata} == {1'b1, VECS[i].xe, VECS[i].xt, VECS[i].xd},
                $sformatf("vector %0d R%0d", i, VECS[i].rq),
                {rsp_valid, rsp_err, rsp_tag, rsp_rdata},
                {1'b1, VECS[i].xe, VECS[i].xt, VECS[i].xd});
        end

        // R8: an idle cycle gives no strobe
        @(negedge clk);
        chk(!rsp_valid, "R8 idle no strobe", {130'd0, rsp_valid}, 131'd0);

        // R5: data load of a freshly tagged slot still hides the tag
        issue(2'd3, 2'd0, 8'h40, VD, 1'b1);
        issue(2'd0, 2'd2, 8'h44, Z, 1'b0);
        chk(!rsp_tag && rsp_rdata == 128'hDEADBEEF, "R5 tagged slot data load",
            {2'd0, rsp_tag, rsp_rdata}, {3'd0, 128'hDEADBEEF});

        // R1: reset mid-run clears tags but keeps data
        issue(2'd2, 2'd0, 8'h40, Z, 1'b0);
        chk(rsp_tag, "R1 tag set before reset", {130'd0, rsp_tag}, 131'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        issue(2'd2, 2'd0, 8'h40, Z, 1'b0);
        chk(!rsp_tag && rsp_rdata == VD, "R1 tag cleared, data kept",
            {2'd0, rsp_tag, rsp_rdata}, {3'd0, VD});

        // R7: unaligned double-word load
        issue(2'd0, 2'd3, 8'h44, Z, 1'b0);
        chk(rsp_err && rsp_rdata == Z, "R7 unaligned dword load",
            {2'd0, rsp_err, rsp_rdata}, {3'd1, Z});

        finish_run();
    end
endmodule